// File: doc/BRIEF.md
# Dual Real/Imaginary Accumulator Pair

This block holds two 20-bit two's-complement adder/subtractor accumulators that run side by side. One serves a real path fed from the 16-bit input A. The other serves an imaginary path fed from the 16-bit input B. Each input has its own capture register and its own active-low load enable. All control inputs are captured on the rising clock edge and take effect one cycle later. These controls are a 2-bit operation code per path, a shared clear, a shared feedback select, a shared 3-bit scale select and a delay select for the real path.

Each cycle, each adder combines its captured input with a second operand. That operand is either zero or the accumulator's own previous result. The 20-bit result is stored back as the new accumulator value. A 16-bit window of the result, chosen by the scale select, is registered onto outputs C (real) and D (imaginary). A single registered flag reports overflow of either adder or of either output window. The per-port active-low output enables drive only valid indications; no tri-state drivers are modelled. An input therefore reaches C or D two clock edges after it is presented.

Top module: `acc_pair`

## Requirements
- R1: While reset is applied and after it is released, with idle inputs, c_out, d_out and ovf read 0; all internal registers start at zero.
- R2: The A capture register loads a_in on a rising edge only when a_ce_n is 0 and otherwise holds. The B capture register behaves the same way under b_ce_n.
- R3: Each path's 2-bit code selects the adder function, with X the captured input and Y the second operand: 0 gives Y, 1 gives X+Y, 2 gives X-Y, 3 gives Y-X. The code acts on the edge after the one that captured it, so an input shows on C/D two edges after it is presented.
- R4: When the captured clear bit is 1, the second operand of both adders is zero, whatever the feedback select says.
- R5: When the captured feedback select is 1 and clear is 0, each adder's second operand is its own previous 20-bit result. When feedback select is 0, the second operand is zero.
- R6: Scale value s from 0 to 4 puts result bits [15+s:s] on the output. Values 5, 6 and 7 act as 4.
- R7: ovf is registered alongside C/D. It is 1 when either 20-bit sum overflows, or when either result has discarded bits above its window that are not all equal to the window's top bit. Scale 4 with code 0 on both paths never raises ovf.
- R8: When the captured delay select is 1, the real adder uses the A register value from the previous enabled load instead of the current one. Both values advance only when a_ce_n is 0.
- R9: c_vld equals the inverse of c_oe_n and d_vld equals the inverse of d_oe_n at all times. C and D data are not affected by the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | 16 | Real-path signed operand |
| b_in | input | 16 | Imaginary-path signed operand |
| a_ce_n | input | 1 | Active-low load enable of the A register (and its delay stage) |
| b_ce_n | input | 1 | Active-low load enable of the B register |
| re_op | input | 2 | Real adder operation code |
| im_op | input | 2 | Imaginary adder operation code |
| clr | input | 1 | Shared clear of the feedback operand |
| fb_sel | input | 1 | Shared feedback select, 1 picks the previous result |
| scale | input | 3 | Output window select |
| dly_sel | input | 1 | Real adder uses the delayed A value |
| c_oe_n | input | 1 | Active-low enable of the C valid indication |
| d_oe_n | input | 1 | Active-low enable of the D valid indication |
| c_out | output | 16 | Real result window |
| d_out | output | 16 | Imaginary result window |
| c_vld | output | 1 | C valid indication |
| d_vld | output | 1 | D valid indication |
| ovf | output | 1 | Registered overflow flag |

## Verification
The assertions assume that every input is stable around the rising edge and that reset stays low long enough to pass through the two-stage release synchronizer. The bench changes all inputs only on the falling edge and keeps them idle until well after reset is released. The hold and clear properties also assume the operation code captured with the control. The stimulus satisfies this because it drives codes and controls together from one pattern generator per phase.

// File: rtl/acc_pair_pkg.sv
package acc_pair_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_RSUB = 2'd3
  } acc_op_e;
endpackage

// File: rtl/acc_pair_rst_sync.sv
module acc_pair_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/acc_pair_lane.sv
module acc_pair_lane
  import acc_pair_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] opd_i,
  input  acc_op_e              op_i,
  input  logic                 fb_i,
  input  logic                 clr_i,
  input  logic [SW-1:0]        scale_i,
  output logic [AW-1:0]        acc_o,
  output logic [DW-1:0]        fld_o,
  output logic                 ovf_nxt_o
);
  localparam int MAXS = AW - DW;
  localparam int UPW  = AW - DW + 1;

  logic signed [AW:0]   x_ext, y_ext, sum;
  logic [AW-1:0]        acc_q, acc_d;
  logic [DW-1:0]        fld_q, fld_d;
  logic [SW-1:0]        sh;
  logic signed [AW-1:0] shv;
  logic [UPW-1:0]       upper;
  logic                 add_ovf, fld_ovf;

  // next-state
  always_comb begin
    x_ext = {{(AW+1-DW){opd_i[DW-1]}}, opd_i};
    y_ext = (fb_i && !clr_i) ? {acc_q[AW-1], acc_q} : '0;
    unique case (op_i)
      OP_PASS: sum = y_ext;
      OP_ADD:  sum = x_ext + y_ext;
      OP_SUB:  sum = x_ext - y_ext;
      default: sum = y_ext - x_ext;
    endcase
    add_ovf = sum[AW] ^ sum[AW-1];
    acc_d   = sum[AW-1:0];
    sh      = (scale_i > SW'(MAXS)) ? SW'(MAXS) : scale_i;
    shv     = $signed(acc_d) >>> sh;
    upper   = shv[AW-1:DW-1];
    fld_ovf = !((&upper) || (~|upper));
    fld_d   = shv[DW-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      fld_q <= '0;
    end else begin
      acc_q <= acc_d;
      fld_q <= fld_d;
    end
  end

  assign acc_o     = acc_q;
  assign fld_o     = fld_q;
  assign ovf_nxt_o = add_ovf | fld_ovf;
endmodule

// File: rtl/acc_pair.sv
module acc_pair
  import acc_pair_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          a_ce_n,
  input  logic          b_ce_n,
  input  logic [1:0]    re_op,
  input  logic [1:0]    im_op,
  input  logic          clr,
  input  logic          fb_sel,
  input  logic [SW-1:0] scale,
  input  logic          dly_sel,
  input  logic          c_oe_n,
  input  logic          d_oe_n,
  output logic [DW-1:0] c_out,
  output logic [DW-1:0] d_out,
  output logic          c_vld,
  output logic          d_vld,
  output logic          ovf
);
  logic          rst_s;
  logic [DW-1:0] a_q, a_dly, b_q, re_opd;
  acc_op_e       re_op_q, im_op_q;
  logic          clr_q, fb_q, dly_q, ovf_q;
  logic [SW-1:0] scale_q;
  logic [AW-1:0] acc_re, acc_im;
  logic          ovf_re, ovf_im;

  acc_pair_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  // capture registers with written-out load enables
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q   <= '0;
      a_dly <= '0;
      b_q   <= '0;
    end else begin
      if (!a_ce_n) begin
        a_q   <= a_in;
        a_dly <= a_q;
      end
      if (!b_ce_n) b_q <= b_in;
    end
  end

  // control capture
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      re_op_q <= OP_PASS;
      im_op_q <= OP_PASS;
      clr_q   <= 1'b0;
      fb_q    <= 1'b0;
      scale_q <= '0;
      dly_q   <= 1'b0;
    end else begin
      re_op_q <= acc_op_e'(re_op);
      im_op_q <= acc_op_e'(im_op);
      clr_q   <= clr;
      fb_q    <= fb_sel;
      scale_q <= scale;
      dly_q   <= dly_sel;
    end
  end

  always_comb re_opd = dly_q ? a_dly : a_q;

  acc_pair_lane #(.DW(DW), .AW(AW), .SW(SW)) u_re (
    .clk(clk), .rst_n(rst_s), .opd_i(re_opd), .op_i(re_op_q),
    .fb_i(fb_q), .clr_i(clr_q), .scale_i(scale_q),
    .acc_o(acc_re), .fld_o(c_out), .ovf_nxt_o(ovf_re)
  );

  acc_pair_lane #(.DW(DW), .AW(AW), .SW(SW)) u_im (
    .clk(clk), .rst_n(rst_s), .opd_i(b_q), .op_i(im_op_q),
    .fb_i(fb_q), .clr_i(clr_q), .scale_i(scale_q),
    .acc_o(acc_im), .fld_o(d_out), .ovf_nxt_o(ovf_im)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ovf_q <= 1'b0;
    else        ovf_q <= ovf_re | ovf_im;
  end

  assign ovf   = ovf_q;
  assign c_vld = ~c_oe_n;
  assign d_vld = ~d_oe_n;

  // R2: A register and its delay stage hold while the load enable is high
  assert_a_hold_R2: assert property (@(posedge clk) disable iff (!rst_s)
    a_ce_n |=> $stable(a_q));
  // R8: delayed operand only advances on enabled loads
  assert_dly_hold_R8: assert property (@(posedge clk) disable iff (!rst_s)
    a_ce_n |=> $stable(a_dly));
  // R4: clear with pass code empties the real accumulator
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (clr_q && re_op_q == OP_PASS) |=> (acc_re == '0));
  // R5: feedback with pass code holds the imaginary accumulator
  assert_fb_hold_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (fb_q && !clr_q && im_op_q == OP_PASS) |=> $stable(acc_im));
  // R7: full-width window with pass codes cannot overflow
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (scale_q >= SW'(AW-DW) && re_op_q == OP_PASS && im_op_q == OP_PASS) |=> !ovf);
endmodule

// File: tb/tb_acc_pair.sv
`timescale 1ns/1ps
module tb_acc_pair;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] a_in, b_in;
  logic a_ce_n, b_ce_n, clr, fb_sel, dly_sel, c_oe_n, d_oe_n;
  logic [1:0] re_op, im_op;
  logic [2:0] scale;
  logic [15:0] c_out, d_out;
  logic c_vld, d_vld, ovf;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  acc_pair dut (.*);

  // arithmetic reference
  logic signed [15:0] m_a, m_ad, m_b;
  logic [1:0] m_ro, m_io;
  logic m_clr, m_fb, m_dly;
  logic [2:0] m_sc;
  int m_accr, m_acci;
  logic [15:0] m_c, m_d;
  logic m_ovf;

  function automatic int wrap20(int r);
    logic signed [19:0] t;
    t = r[19:0];
    return int'(t);
  endfunction

  function automatic int op_res(int x, int y, logic [1:0] op);
    case (op)
      2'd0: return y;
      2'd1: return x + y;
      2'd2: return x - y;
      default: return y - x;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= '0; m_ad <= '0; m_b <= '0; m_ro <= '0; m_io <= '0;
      m_clr <= 0; m_fb <= 0; m_dly <= 0; m_sc <= '0;
      m_accr <= 0; m_acci <= 0; m_c <= '0; m_d <= '0; m_ovf <= 0;
    end else begin : upd
      int yr, yi, rr, ri, wr, wi, fr, fi, s;
      logic o;
      if (!a_ce_n) begin m_a <= a_in; m_ad <= m_a; end
      if (!b_ce_n) m_b <= b_in;
      m_ro <= re_op; m_io <= im_op; m_clr <= clr; m_fb <= fb_sel;
      m_dly <= dly_sel; m_sc <= scale;
      yr = (m_fb && !m_clr) ? m_accr : 0;
      yi = (m_fb && !m_clr) ? m_acci : 0;
      rr = op_res(m_dly ? int'(m_ad) : int'(m_a), yr, m_ro);
      ri = op_res(int'(m_b), yi, m_io);
      wr = wrap20(rr);
      wi = wrap20(ri);
      s  = (m_sc > 3'd4) ? 4 : int'(m_sc);
      fr = wr >>> s;
      fi = wi >>> s;
      o  = (rr != wr) || (ri != wi) || fr > 32767 || fr < -32768 || fi > 32767 || fi < -32768;
      m_accr <= wr; m_acci <= wi;
      m_c <= fr[15:0]; m_d <= fi[15:0]; m_ovf <= o;
    end
  end

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "c_out", c_out, m_c);
    chk(tag, "d_out", d_out, m_d);
    chk(tag, "ovf", {15'd0, ovf}, {15'd0, m_ovf});
    chk(tag, "c_vld", {15'd0, c_vld}, {15'd0, ~c_oe_n});
    chk(tag, "d_vld", {15'd0, d_vld}, {15'd0, ~d_oe_n});
  endtask

  function automatic logic [31:0] nxt(logic [31:0] v);
    return v * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic idle();
    a_in = 0; b_in = 0; a_ce_n = 0; b_ce_n = 0; re_op = 0; im_op = 0;
    clr = 0; fb_sel = 0; scale = 0; dly_sel = 0; c_oe_n = 0; d_oe_n = 0;
  endtask

  // one phase: check at falling edge, then drive the next pattern
  task automatic phase(string tag, int mode, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_all(tag);
      seed = nxt(seed);
      idle();
      a_in = seed[31:16]; b_in = seed[15:0] ^ seed[31:16];
      case (mode)
        2: begin re_op = 1; im_op = 1; a_ce_n = seed[3]; b_ce_n = seed[7]; end
        3: begin re_op = i[1:0]; im_op = i[3:2]; fb_sel = seed[5]; scale = 3'd4; end
        4: begin re_op = 1; im_op = 2; fb_sel = 1; clr = seed[4] & seed[9]; scale = 3'd4; end
        5: begin re_op = 1; im_op = 3; fb_sel = seed[6]; a_in = a_in >>> 4; b_in = b_in >>> 4; end
        6: begin re_op = i[1:0]; im_op = 1; fb_sel = 1; clr = (i % 9 == 0); scale = i[5:3]; end
        7: begin re_op = 1; im_op = 1; fb_sel = 1; a_in = 16'h7fff; b_in = 16'h8000;
                 clr = (i % 40 == 0); scale = i[8:6]; end
        8: begin re_op = 1; im_op = 0; dly_sel = seed[2]; a_ce_n = seed[11] & seed[12]; end
        9: begin re_op = 1; im_op = 1; c_oe_n = seed[1]; d_oe_n = seed[13]; end
        default: begin re_op = seed[1:0]; im_op = seed[9:8]; clr = seed[20] & seed[21];
                 fb_sel = seed[22]; scale = seed[26:24]; dly_sel = seed[27];
                 a_ce_n = seed[28]; b_ce_n = seed[29]; c_oe_n = seed[30]; d_oe_n = seed[14]; end
      endcase
    end
  endtask

  initial begin : wd
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: outputs at zero during reset
    chk("R1", "c_out rst", c_out, 16'h0);
    chk("R1", "ovf rst", {15'd0, ovf}, 16'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_all("R1");
    phase("R2", 2, 300);
    phase("R3", 3, 300);
    phase("R4", 4, 300);
    phase("R5", 5, 300);
    phase("R6", 6, 400);
    phase("R7", 7, 600);
    phase("R8", 8, 300);
    phase("R9", 9, 200);
    phase("R3 mixed", 10, 4000);
    @(negedge clk);
    chk_all("R3 mixed");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule